// File: doc/BRIEF.md
# Burst Read Unpacking Input Buffer

This block brings a contiguous run of narrow array elements into local storage from a wide external memory. A single command gives a starting bus-word address and an element count. The block turns that into one burst read on a memory master port. The port carries address, burst count, read strobe, waitrequest, readdatavalid and readdata. The block holds the request steady while the memory stalls. It then takes each returned beat and splits it into its element lanes. The elements are written into a local buffer at consecutive element indices starting at zero.

The buffer has several independent read ports, one for each parallel loop-body data path. Every data path can fetch a different element in the same cycle. A one-cycle done pulse marks the point where the whole range is present. Commands are taken only while the block is idle.

Top module: `ibuf_top`

## Requirements
- R1: An accepted command issues exactly one burst with mem_address equal to cmd_addr and mem_burstcount equal to ceil(cmd_len / EPB) beats, where EPB = BUS_W / ELEM_W (2 by default).
- R2: While mem_read and mem_waitrequest are both high, mem_read stays high and mem_address and mem_burstcount stay unchanged in the next cycle.
- R3: Element e of a command is stored at buffer index e. It comes from beat e / EPB, lane e % EPB, where lane j occupies readdata bits [j*ELEM_W +: ELEM_W] (lowest lane holds the lowest index).
- R4: Cycles with mem_readdatavalid low write nothing, and the write position advances by EPB only on valid beats.
- R5: When cmd_len is not a multiple of EPB, the unused upper lanes of the last beat are discarded, and buffer entries at indices at or above cmd_len keep their previous contents.
- R6: done is a one-cycle pulse, high in the cycle right after the clock edge that stores the last valid beat, and never high otherwise.
- R7: cmd_ready is high exactly when the block is idle. A command presented while busy is ignored, as is a command with cmd_len of 0 or above DEPTH (64 by default).
- R8: Each of the NRD read ports returns the element at its rd_addr on rd_data one cycle after the address is presented, independently of the other ports.
- R9: After reset, cmd_ready is 1, mem_read is 0, done is 0 and every rd_data lane is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_addr | input | ADDR_W | Starting bus-word address |
| cmd_len | input | LEN_W | Number of elements to fetch (1..DEPTH) |
| cmd_ready | output | 1 | Block idle, command will be taken |
| mem_address | output | ADDR_W | Burst start address |
| mem_burstcount | output | BC_W | Beats in the burst |
| mem_read | output | 1 | Burst read request |
| mem_waitrequest | input | 1 | Memory stall |
| mem_readdatavalid | input | 1 | Returned beat valid |
| mem_readdata | input | BUS_W | Returned beat |
| rd_addr | input | NRD*IDX_W | Read addresses, port p at bits [p*IDX_W +: IDX_W] |
| rd_data | output | NRD*ELEM_W | Read data, port p at bits [p*ELEM_W +: ELEM_W] |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a short odd-length fetch that lands on a buffer already filled by an earlier longer one. This is the only way to see whether the discarded upper lane of the last beat left the old element in place. The bench therefore starts with a full-depth fetch and then issues odd and single-element commands. Its memory model injects random waitrequest stalls, random latency and gaps in readdatavalid. It also presents commands while busy and commands with illegal lengths, then confirms through the burst monitor and the read ports that none of them changed anything.

// File: rtl/ibuf_pkg.sv
// Package: shared state encoding for the burst-read input buffer.
// Assumes: used by ibuf_burst_req only; no parameters live here.
package ibuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } ibuf_state_e;
endpackage

// File: rtl/ibuf_burst_req.sv
// Module: ibuf_burst_req
// Takes a legal command while idle, presents one burst read and holds it
// through waitrequest, then waits in the data phase until the unpacker
// reports the last beat. Assumes the memory returns no data before the
// request is accepted and returns exactly mem_burstcount beats.
module ibuf_burst_req
    import ibuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 7,
    parameter int BC_W   = 6,
    parameter int EPB    = 2,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    input  logic              fin,
    output logic              go,
    output logic [LEN_W-1:0]  len_q,
    output logic [ADDR_W-1:0] mem_address,
    output logic [BC_W-1:0]   mem_burstcount,
    output logic              mem_read,
    input  logic              mem_waitrequest
);
    ibuf_state_e       state;
    logic [ADDR_W-1:0] addr_q;
    logic [BC_W-1:0]   bc_q;
    logic              legal;
    logic [LEN_W:0]    len_round;
    logic [BC_W-1:0]   beats_c;

    // Command legality and beat count rounded up to whole beats
    always_comb begin
        legal     = (cmd_len != '0) && (cmd_len <= LEN_W'(DEPTH));
        len_round = {1'b0, cmd_len} + (LEN_W+1)'(EPB - 1);
        beats_c   = BC_W'(len_round / (LEN_W+1)'(EPB));
    end

    // Request state machine and captured command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            bc_q   <= '0;
            len_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid && legal) begin
                    addr_q <= cmd_addr;
                    bc_q   <= beats_c;
                    len_q  <= cmd_len;
                    state  <= ST_REQ;
                end
                ST_REQ:  if (!mem_waitrequest) state <= ST_DATA;
                ST_DATA: if (fin) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Master port outputs and acceptance strobe
    always_comb begin
        cmd_ready      = (state == ST_IDLE);
        mem_read       = (state == ST_REQ);
        mem_address    = addr_q;
        mem_burstcount = bc_q;
        go             = (state == ST_REQ) && !mem_waitrequest;
    end

    // R2
    hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && mem_waitrequest) |=>
            (mem_read && $stable(mem_address) && $stable(mem_burstcount)));

    // R1
    nonzero_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> (mem_burstcount != '0));
endmodule

// File: rtl/ibuf_unpack.sv
// Module: ibuf_unpack
// Counts returned beats, splits each valid beat into EPB element lanes and
// produces per-lane write enables at the running element position. Lanes at
// or past the command length are not written. Raises fin on the last beat
// and done one cycle later. Assumes go arrives once per burst.
module ibuf_unpack #(
    parameter int ELEM_W = 8,
    parameter int BUS_W  = 16,
    parameter int EPB    = 2,
    parameter int LEN_W  = 7,
    parameter int IDX_W  = 6,
    parameter int BC_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [BC_W-1:0]   bc_in,
    input  logic              rdv,
    input  logic [BUS_W-1:0]  rdata,
    output logic              fin,
    output logic              done,
    output logic [IDX_W-1:0]  wbase,
    output logic [EPB-1:0]    wen,
    output logic [BUS_W-1:0]  wdata
);
    logic             active;
    logic [BC_W-1:0]  beat_q;
    logic [BC_W-1:0]  bc_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] wr_ptr;
    logic             beat_ok;

    // Valid beat and last-beat detection
    always_comb begin
        beat_ok = active && rdv;
        fin     = beat_ok && (beat_q == bc_q - BC_W'(1));
    end

    // Per-lane write enables, masked past the element count
    always_comb begin
        for (int l = 0; l < EPB; l++) begin
            wen[l] = beat_ok &&
                (({1'b0, wr_ptr} + (LEN_W+1)'(l)) < {1'b0, len_q});
        end
        wbase = wr_ptr[IDX_W-1:0];
        wdata = rdata;
    end

    // Beat counter, write position and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat_q <= '0;
            bc_q   <= '0;
            len_q  <= '0;
            wr_ptr <= '0;
            done   <= 1'b0;
        end else begin
            done <= fin;
            if (go) begin
                active <= 1'b1;
                beat_q <= '0;
                bc_q   <= bc_in;
                len_q  <= len_in;
                wr_ptr <= '0;
            end else if (beat_ok) begin
                beat_q <= beat_q + BC_W'(1);
                wr_ptr <= wr_ptr + LEN_W'(EPB);
                if (fin) active <= 1'b0;
            end
        end
    end

    // R5
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (wr_ptr < len_q));

    // R6
    done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/ibuf_mrbuf.sv
// Module: ibuf_mrbuf
// Element buffer with one multi-lane write port (EPB elements at an aligned
// base) and NRD registered read ports. Each read port returns its element
// one cycle after the address. A same-cycle write is seen on the next read.
module ibuf_mrbuf #(
    parameter int ELEM_W = 8,
    parameter int EPB    = 2,
    parameter int DEPTH  = 64,
    parameter int NRD    = 4,
    parameter int IDX_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      wbase,
    input  logic [EPB-1:0]        wen,
    input  logic [EPB*ELEM_W-1:0] wdata,
    input  logic [NRD*IDX_W-1:0]  rd_addr,
    output logic [NRD*ELEM_W-1:0] rd_data
);
    logic [ELEM_W-1:0] mem [DEPTH];

    // Lane writes into consecutive element slots
    always_ff @(posedge clk) begin
        for (int l = 0; l < EPB; l++) begin
            if (wen[l]) mem[wbase + IDX_W'(l)] <= wdata[l*ELEM_W +: ELEM_W];
        end
    end

    // One registered read port per loop body
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n) rd_data[p*ELEM_W +: ELEM_W] <= '0;
            else        rd_data[p*ELEM_W +: ELEM_W] <= mem[rd_addr[p*IDX_W +: IDX_W]];
        end
    end

    // R3
    aligned_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen != '0) |-> ((int'(wbase) % EPB) == 0));
endmodule

// File: rtl/ibuf_top.sv
// Module: ibuf_top
// Burst-read unpacking input buffer. One command fetches cmd_len narrow
// elements starting at bus word cmd_addr, unpacks them little-endian by lane
// and stores them at indices 0..cmd_len-1 for NRD parallel readers.
// Assumes BUS_W is a multiple of ELEM_W and DEPTH a multiple of EPB.
module ibuf_top #(
    parameter int ADDR_W = 32,
    parameter int ELEM_W = 8,
    parameter int BUS_W  = 16,
    parameter int DEPTH  = 64,
    parameter int NRD    = 4,
    localparam int EPB   = BUS_W / ELEM_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int BC_W  = $clog2(DEPTH / EPB + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [LEN_W-1:0]      cmd_len,
    output logic                  cmd_ready,
    output logic [ADDR_W-1:0]     mem_address,
    output logic [BC_W-1:0]       mem_burstcount,
    output logic                  mem_read,
    input  logic                  mem_waitrequest,
    input  logic                  mem_readdatavalid,
    input  logic [BUS_W-1:0]      mem_readdata,
    input  logic [NRD*IDX_W-1:0]  rd_addr,
    output logic [NRD*ELEM_W-1:0] rd_data,
    output logic                  done
);
    logic             go;
    logic             fin;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] wbase;
    logic [EPB-1:0]   wen;
    logic [BUS_W-1:0] wdata;

    ibuf_burst_req #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BC_W(BC_W), .EPB(EPB), .DEPTH(DEPTH)
    ) u_req (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_ready(cmd_ready), .fin(fin), .go(go), .len_q(len_q),
        .mem_address(mem_address), .mem_burstcount(mem_burstcount),
        .mem_read(mem_read), .mem_waitrequest(mem_waitrequest)
    );

    ibuf_unpack #(
        .ELEM_W(ELEM_W), .BUS_W(BUS_W), .EPB(EPB),
        .LEN_W(LEN_W), .IDX_W(IDX_W), .BC_W(BC_W)
    ) u_unpack (
        .clk(clk), .rst_n(rst_n), .go(go), .len_in(len_q),
        .bc_in(mem_burstcount), .rdv(mem_readdatavalid),
        .rdata(mem_readdata), .fin(fin), .done(done),
        .wbase(wbase), .wen(wen), .wdata(wdata)
    );

    ibuf_mrbuf #(
        .ELEM_W(ELEM_W), .EPB(EPB), .DEPTH(DEPTH), .NRD(NRD), .IDX_W(IDX_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .wbase(wbase), .wen(wen), .wdata(wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R7
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    // R7
    no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_read);
endmodule

// File: tb/ibuf_top_tb.sv
module ibuf_top_tb;
    localparam int ADDR_W = 32;
    localparam int ELEM_W = 8;
    localparam int BUS_W  = 16;
    localparam int DEPTH  = 64;
    localparam int NRD    = 4;
    localparam int EPB    = BUS_W / ELEM_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LEN_W  = $clog2(DEPTH + 1);
    localparam int BC_W   = $clog2(DEPTH / EPB + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cmd_valid = 1'b0;
    logic [ADDR_W-1:0]     cmd_addr = '0;
    logic [LEN_W-1:0]      cmd_len = '0;
    logic                  cmd_ready;
    logic [ADDR_W-1:0]     mem_address;
    logic [BC_W-1:0]       mem_burstcount;
    logic                  mem_read;
    logic                  mem_waitrequest = 1'b0;
    logic                  mem_readdatavalid = 1'b0;
    logic [BUS_W-1:0]      mem_readdata = '0;
    logic [NRD*IDX_W-1:0]  rd_addr = '0;
    logic [NRD*ELEM_W-1:0] rd_data;
    logic                  done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model state
    int          wait_pct = 0;
    int          gap_pct = 0;
    int          bursts = 0;
    logic [31:0] last_addr;
    int          last_bc;
    bit          m_busy = 0;
    logic [31:0] m_addr;
    int          m_left;
    int          m_lat;
    bit          expect_done = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr;
    int          prev_bc;
    int          hold_errs = 0;
    int          done_errs = 0;
    logic [7:0]  exp_buf [DEPTH];
    bit          known [DEPTH];

    always #2 clk = ~clk;

    ibuf_top #(
        .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .BUS_W(BUS_W), .DEPTH(DEPTH), .NRD(NRD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_ready(cmd_ready), .mem_address(mem_address),
        .mem_burstcount(mem_burstcount), .mem_read(mem_read),
        .mem_waitrequest(mem_waitrequest), .mem_readdatavalid(mem_readdatavalid),
        .mem_readdata(mem_readdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done)
    );

    function automatic logic [15:0] word_at(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'h9E3779B1 + 32'h1234_5678;
        return t[23:8];
    endfunction

    // R3: element e = beat e/EPB, lane e%EPB, lane j at bits [8j +: 8]
    function automatic logic [7:0] elem_at(input logic [31:0] a, input int e);
        logic [15:0] w;
        w = word_at(a + 32'(e / EPB));
        return w[(e % EPB)*ELEM_W +: ELEM_W];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: all decisions at the falling edge for the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // R6 done timing
                if (expect_done) begin
                    chk(done == 1'b1, "R6", "done after last beat", longint'(done), 1);
                    expect_done = 0;
                end else if (done) begin
                    done_errs++;
                end
                // R2 hold during stall
                if (prev_stall) begin
                    if (!(mem_read && mem_address == prev_addr && int'(mem_burstcount) == prev_bc))
                        hold_errs++;
                end
                mem_readdatavalid = 1'b0;
                if (!m_busy) begin
                    if (mem_read) begin
                        mem_waitrequest = ($urandom_range(0, 99) < wait_pct);
                        if (!mem_waitrequest) begin
                            m_busy = 1;
                            m_addr = mem_address;
                            m_left = int'(mem_burstcount);
                            m_lat = $urandom_range(0, 4);
                            bursts++;
                            last_addr = mem_address;
                            last_bc = int'(mem_burstcount);
                        end
                    end else begin
                        mem_waitrequest = $urandom_range(0, 1);
                    end
                end else begin
                    mem_waitrequest = $urandom_range(0, 1);
                    if (m_lat > 0) begin
                        m_lat--;
                    end else if ($urandom_range(0, 99) >= gap_pct) begin
                        mem_readdatavalid = 1'b1;
                        mem_readdata = word_at(m_addr);
                        m_addr++;
                        m_left--;
                        if (m_left == 0) begin
                            m_busy = 0;
                            expect_done = 1;
                        end
                    end
                    if (!mem_readdatavalid) mem_readdata = $urandom;
                end
                prev_stall = mem_read && mem_waitrequest;
                prev_addr = mem_address;
                prev_bc = int'(mem_burstcount);
            end
        end
    end

    // R8: read every known entry through all ports with rotated addresses
    task automatic check_buf(input string req);
        int rot;
        rot = $urandom_range(0, DEPTH - 1);
        for (int k = 0; k < DEPTH / NRD; k++) begin
            @(negedge clk);
            for (int p = 0; p < NRD; p++)
                rd_addr[p*IDX_W +: IDX_W] = IDX_W'((k * NRD + p * 17 + rot) % DEPTH);
            @(negedge clk);
            for (int p = 0; p < NRD; p++) begin
                int idx;
                idx = (k * NRD + p * 17 + rot) % DEPTH;
                if (known[idx])
                    chk(rd_data[p*ELEM_W +: ELEM_W] == exp_buf[idx], req,
                        $sformatf("buf[%0d] port%0d", idx, p),
                        longint'(rd_data[p*ELEM_W +: ELEM_W]), longint'(exp_buf[idx]));
            end
        end
    endtask

    task automatic do_cmd(input logic [31:0] a, input int len, input bit poke);
        int b0;
        int n;
        b0 = bursts;
        n = 0;
        @(negedge clk);
        while (!cmd_ready && n < 2000) begin @(negedge clk); n++; end
        chk(cmd_ready == 1'b1, "R7", "ready before command", longint'(cmd_ready), 1);
        cmd_valid = 1'b1;
        cmd_addr = a;
        cmd_len = LEN_W'(len);
        @(negedge clk);
        // R7: commands presented while busy are ignored
        if (poke) begin
            cmd_addr = a + 32'h4000;
            cmd_len = LEN_W'(DEPTH);
            chk(cmd_ready == 1'b0, "R7", "ready low when busy", longint'(cmd_ready), 0);
        end else begin
            cmd_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        cmd_valid = 1'b0;
        chk(done == 1'b1, "R6", "done seen", longint'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", longint'(done), 0);
        chk(bursts == b0 + 1, "R1", "one burst per command", bursts, b0 + 1);
        chk(last_addr == a, "R1", "burst address", longint'(last_addr), longint'(a));
        chk(last_bc == (len + EPB - 1) / EPB, "R1", "burst count", last_bc,
            (len + EPB - 1) / EPB);
        for (int e = 0; e < len; e++) begin
            exp_buf[e] = elem_at(a, e);
            known[e] = 1;
        end
        check_buf(len % EPB != 0 ? "R5" : "R3");
    endtask

    task automatic bad_cmd(input int len);
        int b0;
        b0 = bursts;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr = 32'h7777;
        cmd_len = LEN_W'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(bursts == b0, "R7", $sformatf("illegal len %0d no burst", len), bursts, b0);
        chk(cmd_ready == 1'b1, "R7", "still idle", longint'(cmd_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) known[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(cmd_ready == 1'b1, "R9", "cmd_ready", longint'(cmd_ready), 1);
        chk(mem_read == 1'b0, "R9", "mem_read", longint'(mem_read), 0);
        chk(done == 1'b0, "R9", "done", longint'(done), 0);
        chk(rd_data == '0, "R9", "rd_data", longint'(rd_data), 0);

        // full-depth fill, clean memory
        wait_pct = 0; gap_pct = 0;
        do_cmd(32'h100, DEPTH, 0);
        // R5: single element over a full buffer, stalls on
        wait_pct = 60; gap_pct = 0;
        do_cmd(32'h2000, 1, 0);
        // R4: gaps in readdatavalid, odd length
        wait_pct = 30; gap_pct = 50;
        do_cmd(32'h3001, 5, 0);
        // R7: illegal lengths
        bad_cmd(0);
        bad_cmd(DEPTH + 1);
        // R7: commands while busy ignored
        do_cmd(32'h5000, 20, 1);
        // random mix
        for (int t = 0; t < 25; t++) begin
            wait_pct = $urandom_range(0, 80);
            gap_pct = $urandom_range(0, 70);
            do_cmd($urandom, $urandom_range(1, DEPTH), t % 5 == 0);
        end

        chk(hold_errs == 0, "R2", "request held while stalled", hold_errs, 0);
        chk(done_errs == 0, "R6", "no stray done", done_errs, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule